// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a serial peripheral bus wired to a small byte-addressed memory. The bus master selects it by pulling the active-low select low. It then shifts in an 8-bit command code, most significant bit first, and after that any address and data bytes the command takes. Six commands are decoded. Two of them set and clear a write-enable flag. Two read and write an 8-bit status register. Two read and write a 2048-byte internal array. A write to the status register or to the array only takes effect while the write-enable flag is set. Only the set-enable command can set that flag, and it clears itself when select rises at the end of a clear-enable, status-write or memory-write transaction.

The bus pins are oversampled by the system clock through synchronizers. The block needs no configuration for the bus clock phase: each time select falls it checks the idle level of the serial clock. A low level means clock mode 0 and a high level means clock mode 3. In both modes input bits are sampled on rising serial-clock edges and output bits change on falling edges. The output-enable pin tells the pad when the block is driving the data-out line.

Top module: `spi_mem_slave`

## Requirements
- R1: Clock mode 0 (serial clock idles low) and clock mode 3 (serial clock idles high) both work, chosen from the serial clock level at the falling edge of select.
- R2: The first byte of a transaction is the command, shifted most significant bit first: 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read memory, 0x02 write memory. A byte that differs only in bit 7 is not a command.
- R3: After reset the write-enable flag is 0 and the status register reads 0x00.
- R4: A completed 0x06 command sets the write-enable flag. The read-status command returns the status byte with the flag in bit 1 and 0 in bit 0, and repeats that byte for as long as clocks continue.
- R5: Write status with the flag set stores data bits 7..2 into status bits 7..2. Data bit 1 never changes the flag.
- R6: The flag clears at the rise of select that ends a 0x04, 0x01 or 0x02 transaction. Read commands leave it unchanged.
- R7: Read and write memory take a two-byte address, MSB first. Only the low 11 bits select the byte, and read data equals the data written earlier.
- R8: The address advances by one per data byte and wraps from 0x7FF to 0x000.
- R9: Write status or write memory issued while the flag is 0 changes neither the status register nor the memory.
- R10: The output enable is 0 while select is high, during the command and address bytes, and during every write command.
- R11: Input bits are sampled on rising serial-clock edges. The first read bit is driven before the first rising edge of the data phase, and the following bits change on falling edges.
- R12: An unknown command byte causes the rest of the transaction to be ignored. Nothing is driven and no later byte in it is decoded, until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master to slave |
| spi_miso | output | 1 | Serial data from slave to master |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad; 0 means high impedance |

## Verification
A wrong write-enable flag shows up in the next read-status transaction as a wrong bit 1. It also shows up one read transaction later as array bytes that changed when they should have stayed, or that kept old values. A corrupt address counter gives wrong data from the first mismatching byte of a readback. Sweeps of 160 consecutive bytes and a read across the top of the array expose increment and wrap faults. A wrong shift or load of the output register corrupts the byte sampled at the next rising serial clock, and a stray drive enable is caught on the bit during which it appears.

// File: rtl/spi_mem_pkg.sv
// Shared definitions for the serial memory slave: command codes and
// transaction phases. Assumes 8-bit command bytes.
package spi_mem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [7:0] {
        OP_SET_WE  = 8'h06,
        OP_CLR_WE  = 8'h04,
        OP_RD_STAT = 8'h05,
        OP_WR_STAT = 8'h01,
        OP_RD_MEM  = 8'h03,
        OP_WR_MEM  = 8'h02
    } opcode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_STAT_WR,
        PH_STAT_RD,
        PH_MEM_WR,
        PH_MEM_RD,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous bus pins.
// Assumes every bit is independent and that the pin's reset level is RST_VAL.
module spi_mem_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the pins through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_mem_frontend.sv
// Bus front end: synchronizes the pins, detects select and clock edges,
// and works out the clock mode from the idle clock level at select.
// Assumes the serial clock half period spans several system clocks and
// that the clock is steady around the falling edge of select.
module spi_mem_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sel_start,
    output logic sel_end,
    output logic selected,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_bit
);

    logic [2:0] pins_s;
    logic       sck_s;
    logic       cs_s;
    logic       sck_q;
    logic       cs_q;
    logic       mode3;
    logic       seen_rise;

    spi_mem_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({mosi_pin, cs_n_pin, sck_pin}),
        .dout  (pins_s)
    );

    assign sck_s    = pins_s[0];
    assign cs_s     = pins_s[1];
    assign mosi_bit = pins_s[2];

    // Keep previous levels for edge detection and latch the clock mode at select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            mode3 <= 1'b0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (cs_q && !cs_s) begin
                mode3 <= sck_s;
            end
        end
    end

    // Track whether a rising clock edge has occurred in this selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rise <= 1'b0;
        end else if (sel_start) begin
            seen_rise <= 1'b0;
        end else if (sck_rise) begin
            seen_rise <= 1'b1;
        end
    end

    assign selected  = !cs_s;
    assign sel_start = cs_q && !cs_s;
    assign sel_end   = !cs_q && cs_s;
    assign sck_rise  = selected && !sck_q && sck_s;
    // In mode 3 the first falling edge only leaves the idle level.
    assign sck_fall  = selected && sck_q && !sck_s && (!mode3 || seen_rise);

endmodule

// File: rtl/spi_mem_array.sv
// Byte-wide storage with one write port and a registered read port.
// Assumes read data is consumed at least one cycle after the address settles.
module spi_mem_array #(
    parameter int ADDR_BITS = 11
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [7:0]           rdata
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [7:0] mem [DEPTH];

    // Write one byte when enabled and register the read byte every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/spi_mem_ctrl.sv
// Transaction controller: assembles bytes, decodes commands, holds the
// write-enable flag, status bits and address counter, and shifts read data.
// Assumes edge pulses from the front end last one system clock each.
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_BITS  = 11,
    parameter int ADDR_BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_start,
    input  logic                 sel_end,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 mosi_bit,
    input  logic [7:0]           rdata,
    output logic                 mem_we,
    output logic [ADDR_BITS-1:0] mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 wel,
    output logic                 miso,
    output logic                 miso_oe
);

    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int ABC_W  = $clog2(ADDR_BYTES) + 1;
    localparam int STAT_W = BYTE_W - 2;

    phase_e              phase;
    logic [BIT_CW-1:0]   bit_cnt;
    logic [BYTE_W-2:0]   rx_sh;
    logic [BYTE_W-1:0]   rx_byte;
    logic                byte_done;
    logic [ABC_W-1:0]    abyte_cnt;
    logic [ADDR_BITS-1:0] addr_acc;
    logic [ADDR_BITS-1:0] acc_next;
    logic [ADDR_BITS-1:0] addr;
    logic                is_read;
    logic                clr_pend;
    logic [STAT_W-1:0]   stat_hi;
    logic [BYTE_W-1:0]   status_byte;
    logic [BYTE_W-1:0]   tx_sh;
    logic                oe_r;
    logic                rd_phase;
    logic                addr_last;

    assign rx_byte     = {rx_sh, mosi_bit};
    assign byte_done   = sck_rise && (bit_cnt == BIT_CW'(BYTE_W - 1));
    assign acc_next    = ADDR_BITS'({addr_acc, rx_byte});
    assign addr_last   = (abyte_cnt == ABC_W'(ADDR_BYTES - 1));
    assign status_byte = {stat_hi, wel, 1'b0};
    assign rd_phase    = (phase == PH_STAT_RD) || (phase == PH_MEM_RD);

    // Count bits within a byte and shift in sampled data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (sel_start) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sh   <= rx_byte[BYTE_W-2:0];
        end
    end

    // Step the transaction phase on each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_end) begin
            phase <= PH_IDLE;
        end else if (sel_start) begin
            phase <= PH_CMD;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: begin
                    case (rx_byte)
                        OP_SET_WE,
                        OP_CLR_WE:  phase <= PH_IDLE;
                        OP_RD_STAT: phase <= PH_STAT_RD;
                        OP_WR_STAT: phase <= PH_STAT_WR;
                        OP_RD_MEM,
                        OP_WR_MEM:  phase <= PH_ADDR;
                        default:    phase <= PH_SKIP;
                    endcase
                end
                PH_ADDR: begin
                    if (addr_last) begin
                        phase <= is_read ? PH_MEM_RD : PH_MEM_WR;
                    end
                end
                PH_STAT_WR: phase <= PH_IDLE;
                default:    phase <= phase;
            endcase
        end
    end

    // Collect address bytes and advance the address per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abyte_cnt <= '0;
            addr_acc  <= '0;
            addr      <= '0;
            is_read   <= 1'b0;
        end else if (sel_start) begin
            abyte_cnt <= '0;
        end else begin
            if (byte_done && phase == PH_CMD) begin
                is_read <= (rx_byte == OP_RD_MEM);
            end
            if (byte_done && phase == PH_ADDR) begin
                addr_acc  <= acc_next;
                abyte_cnt <= abyte_cnt + 1'b1;
                if (addr_last) begin
                    addr <= acc_next;
                end
            end
            if (byte_done && phase == PH_MEM_WR) begin
                addr <= addr + 1'b1;
            end
            if (sck_fall && phase == PH_MEM_RD && bit_cnt == '0) begin
                addr <= addr + 1'b1;
            end
        end
    end

    // Keep the write-enable flag and the writable status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            clr_pend <= 1'b0;
            stat_hi  <= '0;
        end else if (sel_start) begin
            clr_pend <= 1'b0;
        end else if (sel_end) begin
            if (clr_pend) begin
                wel <= 1'b0;
            end
        end else if (byte_done) begin
            if (phase == PH_CMD) begin
                if (rx_byte == OP_SET_WE) begin
                    wel <= 1'b1;
                end
                if (rx_byte == OP_CLR_WE || rx_byte == OP_WR_STAT ||
                    rx_byte == OP_WR_MEM) begin
                    clr_pend <= 1'b1;
                end
            end
            if (phase == PH_STAT_WR && wel) begin
                stat_hi <= rx_byte[BYTE_W-1:2];
            end
        end
    end

    // Load and shift outgoing data on falling clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_start || sel_end) begin
            tx_sh <= '0;
            oe_r  <= 1'b0;
        end else if (sck_fall && rd_phase) begin
            if (bit_cnt == '0) begin
                tx_sh <= (phase == PH_MEM_RD) ? rdata : status_byte;
                oe_r  <= 1'b1;
            end else begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign mem_we    = byte_done && (phase == PH_MEM_WR) && wel;
    assign mem_addr  = addr;
    assign mem_wdata = rx_byte;
    assign miso      = tx_sh[BYTE_W-1];
    assign miso_oe   = oe_r;

endmodule

// File: rtl/spi_mem_slave.sv
// Top of the serial memory slave: front end, controller and byte array.
// Assumes the system clock runs several times faster than the serial clock.
module spi_mem_slave #(
    parameter int ADDR_BITS   = 11,
    parameter int ADDR_BYTES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);

    logic                 sel_start;
    logic                 sel_end;
    logic                 selected;
    logic                 sck_rise;
    logic                 sck_fall;
    logic                 mosi_bit;
    logic                 mem_we;
    logic [ADDR_BITS-1:0] mem_addr;
    logic [7:0]           mem_wdata;
    logic [7:0]           mem_rdata;
    logic                 wel;

    spi_mem_frontend #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_pin   (spi_sck),
        .cs_n_pin  (spi_cs_n),
        .mosi_pin  (spi_mosi),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .selected  (selected),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_bit  (mosi_bit)
    );

    spi_mem_ctrl #(
        .ADDR_BITS  (ADDR_BITS),
        .ADDR_BYTES (ADDR_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_bit  (mosi_bit),
        .rdata     (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .wel       (wel),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    spi_mem_array #(
        .ADDR_BITS (ADDR_BITS)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_mem_slave_chk.sv
// Property checker for the serial memory slave, bound to its top module.
// Assumes the internal edge pulses of the top are visible by name.
module spi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_end,
    input logic selected,
    input logic sck_fall,
    input logic wel,
    input logic mem_we,
    input logic spi_miso_oe
);

    assert_wel_clear_after_reset_R3: assert property (
        @(posedge clk) !rst_n |=> !wel);

    assert_wel_sets_only_selected_R4: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(wel) |-> $past(selected));

    assert_wel_drops_at_deselect_R6: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(wel) |-> $past(sel_end));

    assert_write_needs_wel_R9: assert property (
        @(posedge clk) disable iff (!rst_n) mem_we |-> wel);

    assert_no_drive_deselected_R10: assert property (
        @(posedge clk) disable iff (!rst_n) !selected |=> !spi_miso_oe);

    assert_drive_starts_on_fall_R11: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(spi_miso_oe) |-> $past(sck_fall));

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_end     (sel_end),
    .selected    (selected),
    .sck_fall    (sck_fall),
    .wel         (wel),
    .mem_we      (mem_we),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;

    localparam int HALF  = 8;
    localparam int DEPTH = 2048;
    localparam int BUF_N = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] tx_buf [BUF_N];
    logic [7:0] rx_buf [BUF_N];
    int         oe_cnt [BUF_N];
    logic [7:0] model  [DEPTH];
    logic       wel_m = 1'b0;
    logic [5:0] stat_m = '0;

    always #4 clk = ~clk;

    spi_mem_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One selection of n bytes from tx_buf in mode 0 (m3=0) or mode 3.
    task automatic run_txn(input bit m3, input int n);
        sck = m3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            oe_cnt[i] = 0;
            for (int b = 7; b >= 0; b--) begin
                if (m3) sck = 1'b0;
                mosi = tx_buf[i][b];
                wait_clk(HALF);
                rx_buf[i][b] = miso;
                if (miso_oe) oe_cnt[i]++;
                sck = 1'b1;
                wait_clk(HALF);
                if (!m3) sck = 1'b0;
            end
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
        chk("R10 idle", miso_oe, 0);
    endtask

    function automatic logic [7:0] stat_exp();
        return {stat_m, wel_m, 1'b0};
    endfunction

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'(s * 7 + i * 29 + (i >> 2));
    endfunction

    task automatic cmd1(input bit m3, input logic [7:0] op);
        tx_buf[0] = op;
        run_txn(m3, 1);
        if (op == 8'h06) wel_m = 1'b1;
        if (op == 8'h04) wel_m = 1'b0;
    endtask

    task automatic rdsr(input bit m3, input string req);
        tx_buf[0] = 8'h05;
        tx_buf[1] = 8'h00;
        tx_buf[2] = 8'h00;
        run_txn(m3, 3);
        chk(req, rx_buf[1], stat_exp());
        chk(req, rx_buf[2], stat_exp());
        chk("R10 opcode", oe_cnt[0], 0);
        chk("R11 drive", oe_cnt[1], 8);
    endtask

    task automatic wrsr(input bit m3, input logic [7:0] val);
        tx_buf[0] = 8'h01;
        tx_buf[1] = val;
        run_txn(m3, 2);
        if (wel_m) stat_m = val[7:2];
        wel_m = 1'b0;
    endtask

    task automatic mwrite(input bit m3, input logic [15:0] a, input int n, input int s);
        int tot;
        tx_buf[0] = 8'h02;
        tx_buf[1] = a[15:8];
        tx_buf[2] = a[7:0];
        for (int i = 0; i < n; i++) begin
            tx_buf[3 + i] = pat(s, i);
            if (wel_m) model[(int'(a) + i) % DEPTH] = pat(s, i);
        end
        run_txn(m3, n + 3);
        wel_m = 1'b0;
        tot = 0;
        for (int i = 0; i < n + 3; i++) tot += oe_cnt[i];
        chk("R10 write", tot, 0);
    endtask

    task automatic mread(input bit m3, input logic [15:0] a, input int n, input string req);
        tx_buf[0] = 8'h03;
        tx_buf[1] = a[15:8];
        tx_buf[2] = a[7:0];
        for (int i = 0; i < n; i++) tx_buf[3 + i] = 8'h00;
        run_txn(m3, n + 3);
        chk("R10 addr", oe_cnt[1] + oe_cnt[2], 0);
        for (int i = 0; i < n; i++) begin
            chk(req, rx_buf[3 + i], model[(int'(a) + i) % DEPTH]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(10);
        chk("R10 reset", miso_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);

        rdsr(1'b0, "R3");
        cmd1(1'b0, 8'h06);
        rdsr(1'b0, "R4");
        cmd1(1'b1, 8'h04);
        rdsr(1'b1, "R6");
        cmd1(1'b1, 8'h06);
        rdsr(1'b1, "R1");

        // Status write: data bit 1 never reaches the flag.
        wrsr(1'b0, 8'hFF);
        rdsr(1'b0, "R5");
        wrsr(1'b0, 8'h00);
        rdsr(1'b0, "R9");
        cmd1(1'b0, 8'h06);
        wrsr(1'b1, 8'h02);
        rdsr(1'b0, "R5");

        // Opcode with bit 7 set must not act as set-enable.
        cmd1(1'b0, 8'h86);
        rdsr(1'b0, "R2");

        cmd1(1'b0, 8'h06);
        mwrite(1'b0, 16'h0040, 160, 3);
        rdsr(1'b0, "R6");
        cmd1(1'b1, 8'h06);
        mread(1'b0, 16'h0040, 160, "R7");
        rdsr(1'b1, "R6");
        cmd1(1'b0, 8'h04);

        cmd1(1'b1, 8'h06);
        mwrite(1'b1, 16'hFFFE, 4, 11);
        mread(1'b1, 16'h07FE, 4, "R8");
        mread(1'b0, 16'h0000, 2, "R8");
        mread(1'b1, 16'h0041, 1, "R11");

        mwrite(1'b0, 16'h0040, 8, 99);
        mread(1'b0, 16'h0040, 8, "R9");

        tx_buf[0] = 8'hAB;
        tx_buf[1] = 8'h06;
        tx_buf[2] = 8'h05;
        tx_buf[3] = 8'h00;
        run_txn(1'b0, 4);
        chk("R12 quiet", oe_cnt[0] + oe_cnt[1] + oe_cnt[2] + oe_cnt[3], 0);
        rdsr(1'b1, "R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule